// File: doc/BRIEF.md
# Configurable Serial Receive Framer

This block is the receive front end of a synchronous serial link of the kind used for audio samples. It watches a bit clock that has already been brought into the system clock domain. On one selectable edge of that bit clock it samples the serial data line and the frame sync line. It finds the start of each frame from the sync line and turns the data bits that follow into parallel words, most significant bit first. The sync line's active level, its expected duration and its position relative to the first data bit are all set by static configuration inputs. The word length is picked from eight encoded sizes.

A frame may carry any number of back-to-back words. Each finished word appears on `word_data`, right-justified, together with a one-cycle `word_valid` pulse. `frame_start` pulses once for every accepted sync. In bit-long sync mode, a new sync in the middle of a word drops the partial word and starts over. In word-long sync mode, the sync is expected to stay asserted through the first word, so sync activity inside that word is ignored. The configuration inputs are meant to change only while reset is held.

Top module: `serial_rx_framer`

## Requirements
- R1: After reset `word_data`, `word_valid` and `frame_start` are 0, and no word is produced until the first frame sync has been accepted.
- R2: With `cfg_rise_edge`=1, data and sync are sampled in the system clock cycle in which `bclk` is seen going from 0 to 1.
- R3: With `cfg_rise_edge`=0, data and sync are sampled in the cycle in which `bclk` is seen going from 1 to 0.
- R4: The sync is active when `fsync` is 1 if `cfg_fs_low`=0, and when `fsync` is 0 if `cfg_fs_low`=1. A sync is accepted on a sample where it is active and the previous sample was inactive.
- R5: Bits are shifted in MSB first. After the configured number of bits the word is placed right-justified on `word_data` (upper bits 0), `word_valid` pulses for one cycle, and the next word of the frame follows immediately with no gap.
- R6: `cfg_wl_sel` values 0 to 7 select word lengths 8, 10, 12, 16, 18, 20, 22 and 24 bits.
- R7: With `cfg_fs_early`=0, the sample on which the sync is accepted carries the MSB of the first word.
- R8: With `cfg_fs_early`=1, the sample on which the sync is accepted carries no data, and the MSB of the first word is on the next sample.
- R9: With `cfg_fs_bit`=1 (sync one bit long), an accepted sync in the middle of a word discards the partial word and restarts framing at that sync.
- R10: With `cfg_fs_bit`=0 (sync one word long), sync samples during the word length minus one samples after an accepted sync are ignored, so a dropout and re-assertion of the sync inside the first word leaves that word intact.
- R11: `frame_start` is a one-cycle pulse in the cycle after each accepted sync, exactly one per accepted sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock, already synchronous to `clk` |
| sdata | input | 1 | Serial data |
| fsync | input | 1 | Frame sync line |
| cfg_rise_edge | input | 1 | 1: sample on rising edge of `bclk`, 0: on falling edge |
| cfg_fs_low | input | 1 | 1: sync active low, 0: active high |
| cfg_fs_bit | input | 1 | 1: sync lasts one bit, 0: sync lasts one word |
| cfg_fs_early | input | 1 | 1: sync one bit before first data bit, 0: on first data bit |
| cfg_wl_sel | input | 3 | Word length code (8, 10, 12, 16, 18, 20, 22, 24) |
| word_data | output | 24 | Last completed word, right-justified |
| word_valid | output | 1 | One-cycle strobe for a new word |
| frame_start | output | 1 | One-cycle strobe for an accepted sync |

## Verification
A wrong bit counter or a bad lock state shows at the port as a missing, extra or bit-rotated word. This appears no later than the end of the first word after the fault. Sampling on the wrong edge shifts every word by one bit, so it is visible on the first word. A sync detector that mis-tracks its holdoff or its previous sample gives an extra or a missing `frame_start`, which shows in the frame count. It also shows in word contents within the same frame: an abort that should not happen truncates the word, and an abort that should happen lets a stale partial word through.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int unsigned SRF_MAXW = 24;
  localparam int unsigned SRF_SELW = 3;
  localparam int unsigned SRF_CW   = $clog2(SRF_MAXW + 1);

  typedef logic [SRF_CW-1:0] srf_len_t;

  typedef struct packed {
    logic                rise;
    logic                fs_low;
    logic                fs_bit;
    logic                early;
    logic [SRF_SELW-1:0] wl_sel;
  } srf_cfg_t;

  function automatic srf_len_t srf_wl_decode(input logic [SRF_SELW-1:0] sel);
    srf_len_t len;
    case (sel)
      3'd0:    len = srf_len_t'(8);
      3'd1:    len = srf_len_t'(10);
      3'd2:    len = srf_len_t'(12);
      3'd3:    len = srf_len_t'(16);
      3'd4:    len = srf_len_t'(18);
      3'd5:    len = srf_len_t'(20);
      3'd6:    len = srf_len_t'(22);
      default: len = srf_len_t'(24);
    endcase
    return len;
  endfunction
endpackage

// File: rtl/srf_edge_sel.sv
module srf_edge_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic rise,
  output logic strobe
);
  logic bclk_q;
  logic bclk_d;

  always_comb begin
    bclk_d = bclk;
    strobe = rise ? (bclk & ~bclk_q) : (~bclk & bclk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk_d;
  end

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

// File: rtl/srf_sync_det.sv
module srf_sync_det #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          fs_line,
  input  logic          fs_low,
  input  logic          fs_bit,
  input  logic [CW-1:0] wl,
  output logic          start
);
  logic          act;
  logic          prev_q, prev_d;
  logic [CW-1:0] hold_q, hold_d;

  always_comb begin
    act    = fs_line ^ fs_low;
    start  = strobe & act & ~prev_q & (hold_q == '0);
    prev_d = prev_q;
    hold_d = hold_q;
    if (strobe) begin
      prev_d = act;
      if (start)
        hold_d = fs_bit ? '0 : (wl - 1'b1);
      else if (hold_q != '0)
        hold_d = hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= '0;
    end else begin
      prev_q <= prev_d;
      hold_q <= hold_d;
    end
  end

  // R10
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !fs_bit) |=> (hold_q != '0));
  // R9
  bit_mode_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fs_bit) |=> (hold_q == '0));
endmodule

// File: rtl/srf_word_asm.sv
module srf_word_asm #(
  parameter int unsigned MAXW = 24,
  parameter int unsigned CW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic            start,
  input  logic            early,
  input  logic            sdata,
  input  logic [CW-1:0]   wl,
  output logic [MAXW-1:0] word_data,
  output logic            word_valid,
  output logic            frame_start
);
  localparam logic [MAXW-1:0] ONE = {{(MAXW-1){1'b0}}, 1'b1};

  logic            lock_q, lock_d;
  logic [CW-1:0]   cnt_q, cnt_d, cnt_inc;
  logic [MAXW-1:0] sh_q, sh_d, mask;
  logic [MAXW-1:0] data_q, data_d;
  logic            vld_q, vld_d;
  logic            fst_q, fst_d;

  always_comb begin
    mask    = (ONE << wl) - ONE;
    cnt_inc = cnt_q + 1'b1;
    lock_d  = lock_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    data_d  = data_q;
    vld_d   = 1'b0;
    fst_d   = 1'b0;
    if (strobe) begin
      if (start) begin
        lock_d = 1'b1;
        fst_d  = 1'b1;
        if (early) begin
          cnt_d = '0;
          sh_d  = '0;
        end else begin
          cnt_d = {{(CW-1){1'b0}}, 1'b1};
          sh_d  = {{(MAXW-1){1'b0}}, sdata};
        end
      end else if (lock_q) begin
        sh_d = {sh_q[MAXW-2:0], sdata};
        if (cnt_inc == wl) begin
          vld_d  = 1'b1;
          data_d = sh_d & mask;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_inc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
      fst_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      data_q <= data_d;
      vld_q  <= vld_d;
      fst_q  <= fst_d;
    end
  end

  assign word_data   = data_q;
  assign word_valid  = vld_q;
  assign frame_start = fst_q;

  // R5
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  // R1
  valid_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> lock_q);
  // R11
  fstart_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!word_valid && lock_q));
  // R11
  fstart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer #(
  parameter int unsigned MAXW = srf_pkg::SRF_MAXW,
  parameter int unsigned SELW = srf_pkg::SRF_SELW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bclk,
  input  logic            sdata,
  input  logic            fsync,
  input  logic            cfg_rise_edge,
  input  logic            cfg_fs_low,
  input  logic            cfg_fs_bit,
  input  logic            cfg_fs_early,
  input  logic [SELW-1:0] cfg_wl_sel,
  output logic [MAXW-1:0] word_data,
  output logic            word_valid,
  output logic            frame_start
);
  import srf_pkg::*;
  localparam int unsigned CW = SRF_CW;

  srf_cfg_t cfg;
  srf_len_t wl;
  logic     strobe;
  logic     start;

  always_comb begin
    cfg.rise   = cfg_rise_edge;
    cfg.fs_low = cfg_fs_low;
    cfg.fs_bit = cfg_fs_bit;
    cfg.early  = cfg_fs_early;
    cfg.wl_sel = cfg_wl_sel;
    wl         = srf_wl_decode(cfg.wl_sel);
  end

  srf_edge_sel u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .bclk   (bclk),
    .rise   (cfg.rise),
    .strobe (strobe)
  );

  srf_sync_det #(.CW(CW)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .fs_line (fsync),
    .fs_low  (cfg.fs_low),
    .fs_bit  (cfg.fs_bit),
    .wl      (wl),
    .start   (start)
  );

  srf_word_asm #(.MAXW(MAXW), .CW(CW)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .start       (start),
    .early       (cfg.early),
    .sdata       (sdata),
    .wl          (wl),
    .word_data   (word_data),
    .word_valid  (word_valid),
    .frame_start (frame_start)
  );
endmodule

// File: tb/serial_rx_framer_bench.sv
module serial_rx_framer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk, sdata, fsync;
  logic        cfg_rise_edge, cfg_fs_low, cfg_fs_bit, cfg_fs_early;
  logic [2:0]  cfg_wl_sel;
  logic [23:0] word_data;
  logic        word_valid, frame_start;

  int total = 0;
  int bad   = 0;
  bit          dq[$];
  bit          fq[$];
  logic [23:0] expq[$];
  logic [23:0] gotq[$];
  int          nfs = 0;
  int          exp_fs = 0;

  always #10 clk = ~clk;

  serial_rx_framer u_serial_rx_framer (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .sdata(sdata), .fsync(fsync),
    .cfg_rise_edge(cfg_rise_edge), .cfg_fs_low(cfg_fs_low),
    .cfg_fs_bit(cfg_fs_bit), .cfg_fs_early(cfg_fs_early),
    .cfg_wl_sel(cfg_wl_sel), .word_data(word_data),
    .word_valid(word_valid), .frame_start(frame_start)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid)  gotq.push_back(word_data);
      if (frame_start) nfs++;
    end
  end

  function automatic int wl_of(input logic [2:0] s);
    case (s)
      3'd0: return 8;   3'd1: return 10;  3'd2: return 12;  3'd3: return 16;
      3'd4: return 18;  3'd5: return 20;  3'd6: return 22;  default: return 24;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input bit r, input bit inv, input bit bl, input bit e, input logic [2:0] w);
    cfg_rise_edge = r; cfg_fs_low = inv; cfg_fs_bit = bl; cfg_fs_early = e; cfg_wl_sel = w;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bclk = 1'b0; sdata = 1'b0; fsync = cfg_fs_low;
    dq.delete(); fq.delete(); expq.delete(); gotq.delete();
    nfs = 0; exp_fs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_bit(input bit d, input bit f);
    dq.push_back(d); fq.push_back(f);
  endtask

  task automatic add_pad(input int n);
    for (int i = 0; i < n; i++) push_bit(1'($urandom), 1'b0);
  endtask

  // glitch: drop sync at bit 3 and raise it again at bit 4 of the first word
  task automatic add_frame(input int nw, input bit glitch);
    int wl;
    logic [23:0] w;
    bit f;
    wl = wl_of(cfg_wl_sel);
    exp_fs++;
    if (cfg_fs_early) push_bit(1'($urandom), 1'b1);
    for (int k = 0; k < nw; k++) begin
      w = 24'($urandom) & 24'((32'd1 << wl) - 1);
      expq.push_back(w);
      for (int idx = 0; idx < wl; idx++) begin
        if (k != 0) f = 1'b0;
        else if (cfg_fs_bit) f = !cfg_fs_early && (idx == 0);
        else f = cfg_fs_early ? (idx <= wl - 2) : 1'b1;
        if (glitch && k == 0 && idx == 3) f = 1'b0;
        if (glitch && k == 0 && idx == 4) f = 1'b1;
        push_bit(w[wl-1-idx], f);
      end
    end
  endtask

  task automatic add_partial(input int nb);
    exp_fs++;
    if (cfg_fs_early) push_bit(1'($urandom), 1'b1);
    for (int idx = 0; idx < nb; idx++)
      push_bit(1'($urandom), !cfg_fs_early && (idx == 0));
  endtask

  task automatic drive_bit(input bit d, input bit f);
    bclk = cfg_rise_edge ? 1'b0 : 1'b1;
    repeat (2) @(negedge clk);
    sdata = d;
    fsync = f ^ cfg_fs_low;
    repeat (2) @(negedge clk);
    bclk = cfg_rise_edge ? 1'b1 : 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic play();
    for (int i = 0; i < dq.size(); i++) drive_bit(dq[i], fq[i]);
    dq.delete(); fq.delete();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_check(input string tag);
    int n;
    chk({tag, " word count"}, 32'(gotq.size()), 32'(expq.size()));
    n = (gotq.size() < expq.size()) ? gotq.size() : expq.size();
    for (int i = 0; i < n; i++) chk({tag, " word"}, 32'(gotq[i]), 32'(expq[i]));
    // R11 one frame_start per accepted sync
    chk({tag, " R11 frames"}, 32'(nfs), 32'(exp_fs));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c5a_0b7e));
    set_cfg(1, 0, 1, 0, 3'd0);
    do_reset();
    // R1 reset state
    chk("R1 reset data", 32'(word_data), 0);
    chk("R1 reset valid", 32'(word_valid), 0);
    chk("R1 reset fstart", 32'(frame_start), 0);
    // R1 no words before first sync
    add_pad(30); play();
    finish_check("R1");

    // R2 R5 R7: rising edge, active high, bit sync, on first bit, 8 bits
    set_cfg(1, 0, 1, 0, 3'd0); do_reset();
    add_pad(3); add_frame(3, 0); add_pad(2); add_frame(2, 0); play();
    finish_check("R2 R5 R7");

    // R3 R4: falling edge, active low sync, 24 bits
    set_cfg(0, 1, 1, 0, 3'd7); do_reset();
    add_pad(2); add_frame(2, 0); add_pad(2); add_frame(1, 0); play();
    finish_check("R3 R4");

    // R8: early sync, 10 bits
    set_cfg(1, 1, 1, 1, 3'd1); do_reset();
    add_pad(2); add_frame(3, 0); add_pad(2); add_frame(2, 0); play();
    finish_check("R8");

    // R10: word-long sync with dropout inside the first word
    set_cfg(0, 0, 0, 0, 3'd3); do_reset();
    add_pad(2); add_frame(2, 1); add_pad(2); add_frame(1, 0); play();
    finish_check("R10 late");
    set_cfg(1, 0, 0, 1, 3'd2); do_reset();
    add_pad(2); add_frame(2, 1); play();
    finish_check("R10 early");

    // R9: bit-long sync mid-word aborts
    set_cfg(1, 0, 1, 0, 3'd4); do_reset();
    add_pad(2); add_frame(1, 0); add_partial(7); add_frame(2, 0); play();
    finish_check("R9 late");
    set_cfg(0, 1, 1, 1, 3'd0); do_reset();
    add_pad(2); add_partial(5); add_frame(2, 0); play();
    finish_check("R9 early");

    // R6: every word length code
    for (int s = 0; s < 8; s++) begin
      set_cfg(1, 0, 1, 0, 3'(s)); do_reset();
      add_pad(2); add_frame(2, 0); play();
      finish_check("R6");
    end

    // random mix of all modes: R2 R3 R4 R5 R7 R8 R9 R10
    for (int it = 0; it < 20; it++) begin
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
      do_reset();
      add_pad(2);
      for (int fr = 0; fr < 3; fr++) begin
        if (cfg_fs_bit && ($urandom % 3 == 0)) add_partial(2 + ($urandom % 5));
        add_frame(1 + ($urandom % 3), !cfg_fs_bit && ($urandom % 2 == 0));
        add_pad(2);
      end
      play();
      finish_check("R5 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule